// File: doc/BRIEF.md
# Word-Clock-Aligned Stereo Serial Transmitter

This block turns one stereo sample pair into a serial stream. The stream runs on a 64-slot frame made of two 32-slot fields, with the left field first and the right field second. A left/right clock input selects the field. A word-clock input sets the point in each field where the sample word begins. Until that point the output carries zeros. The word then goes out MSB first. After its last bit, zeros fill the rest of the field.

The word clock is evaluated again in every field. One field can therefore be right-justified while the next uses the one-slot-delayed I2S-style placement, or any position between the two. All logic runs on the falling edge of the bit clock. The downstream receiver samples on the rising edge, when the output is stable. Samples come in on a parallel port with a load strobe. They are held in a staging register and copied into the per-channel shift registers at the start of each frame.

Top module: `audtx_wclk_tx`

## Requirements
- R1: A field begins at the first falling edge of `bclk` where the sampled `lrclk` differs from its value at the previous falling edge. That edge drives slot 1 of the field, and slot 1 always carries 0. `lrclk` low selects the left field (frame start) and high selects the right field. Each field is 32 slots long.
- R2: `sd` changes only on falling edges of `bclk`. `lrclk`, `wck`, `load` and the sample inputs are all sampled on falling edges. The value driven at the falling edge that opens slot n is the bit for slot n.
- R3: While `wck` has not been sampled high in the current field, `sd` is 0. If `wck` is first sampled high in slot k, the MSB appears in slot k+1 and the remaining bits follow in consecutive slots, MSB first.
- R4: If `wck` is high in slot 1 of a field, the MSB appears in slot 2, which gives the I2S-style placement.
- R5: If `wck` first goes high in slot 32 − WORD_W (slot 16 for 16-bit words, slot 14 for 18-bit words), the LSB lands in slot 32, which gives a right-justified word.
- R6: After the LSB, `sd` stays 0 until the field ends. Further `wck` activity in that field has no effect.
- R7: Alignment is independent per field. The left and right words of one frame may use different start slots.
- R8: A word that would run past slot 32 is cut off at the field boundary, and none of its bits leak into the next field. If `wck` is never high in a field, or first goes high only in slot 32, the whole field is 0.
- R9: A falling edge with `load` high copies `left_in` and `right_in` into a staging register. The left-field slot-1 edge copies the staging contents, as held before that edge, into both shift registers. A load made during a frame therefore appears only in the next frame. The data inputs are ignored while `load` is low.
- R10: While `rst_n` is low, `sd` is 0 and the staging and shift registers are cleared. Fields before the first frame start after reset output only zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock. All state changes on its falling edge. |
| rst_n | input | 1 | Asynchronous active-low reset. |
| lrclk | input | 1 | Field select: low for left, high for right. A change marks slot 1. |
| wck | input | 1 | Word clock. Its first high sample in a field sets the word start. |
| load | input | 1 | Load strobe for the staging register. |
| left_in | input | WORD_W | Left sample, taken when `load` is high. |
| right_in | input | WORD_W | Right sample, taken when `load` is high. |
| sd | output | 1 | Serial data, MSB first, zero padded. |

## Verification
The bench builds two copies side by side from the same stimulus: one with WORD_W = 16 and one with WORD_W = 18. Because both copies see the same word clock, a single edge placement is right-justified for one width and truncated or left-padded for the other. This brings the slot-16 and slot-14 right-justified starts and the overrun cut-off into reach together. Random start slots per field, random word-clock chatter after the start, and loads placed at arbitrary slots (including the frame's own first slot) cover per-field independence and capture timing.

// File: rtl/audtx_pkg.sv
package audtx_pkg;

  // Slots per field; two fields per frame.
  localparam int unsigned FIELD_LEN = 32;

  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;

  // Slot that carries the MSB when the word clock is first seen high in slot k.
  function automatic int unsigned msb_slot(input int unsigned k);
    return k + 1;
  endfunction

  // Word-clock slot that places the LSB on the last slot of the field.
  function automatic int unsigned rj_strobe_slot(input int unsigned w);
    return FIELD_LEN - w;
  endfunction

  // True when a word of width w started by a strobe in slot k fits the field.
  function automatic logic word_fits(input int unsigned k, input int unsigned w);
    return (msb_slot(k) + w - 1) <= FIELD_LEN;
  endfunction

endpackage

// File: rtl/audtx_field_ctrl.sv
module audtx_field_ctrl
  import audtx_pkg::*;
#(
  parameter int unsigned FLEN = FIELD_LEN,
  localparam int unsigned SW  = $clog2(FLEN + 1)
) (
  input  logic          bclk,
  input  logic          rst_n,
  input  logic          lrclk,
  input  logic          wck,
  output logic          field_start,
  output logic          frame_start,
  output logic          armed_q,
  output logic          emit,
  output chan_e         chan,
  output logic [SW-1:0] slot_q
);

  logic lr_q;

  // A change of the sampled field select opens a new field.
  assign field_start = lrclk ^ lr_q;
  assign frame_start = field_start & ~lrclk;
  assign chan        = chan_e'(lrclk);

  // Word bits may be driven once the word clock was seen at an earlier edge.
  assign emit = armed_q & ~field_start;

  always_ff @(negedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      lr_q    <= 1'b0;
      armed_q <= 1'b0;
      slot_q  <= '0;
    end else begin
      lr_q <= lrclk;
      if (field_start) begin
        armed_q <= wck;
        slot_q  <= SW'(1);
      end else begin
        armed_q <= armed_q | wck;
        if (slot_q != '0 && slot_q != SW'(FLEN)) begin
          slot_q <= slot_q + SW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/audtx_lane.sv
module audtx_lane #(
  parameter int unsigned WORD_W = 16,
  localparam int unsigned CW    = $clog2(WORD_W + 1)
) (
  input  logic              bclk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [WORD_W-1:0] din,
  input  logic              advance,
  output logic              bit_o,
  output logic              busy
);

  logic [WORD_W-1:0] sh_q;
  logic [CW-1:0]     left_q;

  assign busy  = (left_q != '0);
  assign bit_o = sh_q[WORD_W-1] & busy;

  always_ff @(negedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (capture) begin
      sh_q   <= din;
      left_q <= CW'(WORD_W);
    end else if (advance && busy) begin
      sh_q   <= {sh_q[WORD_W-2:0], 1'b0};
      left_q <= left_q - CW'(1);
    end
  end

endmodule

// File: rtl/audtx_wclk_tx.sv
module audtx_wclk_tx
  import audtx_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  localparam int unsigned SW    = $clog2(FIELD_LEN + 1)
) (
  input  logic              bclk,
  input  logic              rst_n,
  input  logic              lrclk,
  input  logic              wck,
  input  logic              load,
  input  logic [WORD_W-1:0] left_in,
  input  logic [WORD_W-1:0] right_in,
  output logic              sd
);

  logic              field_start;
  logic              frame_start;
  logic              armed_q;
  logic              emit;
  chan_e             chan;
  logic [SW-1:0]     slot_q;
  logic [WORD_W-1:0] stage_q [2];
  logic [1:0]        lane_bit;
  logic [1:0]        lane_busy;
  logic              word_active;
  logic              sd_d;

  audtx_field_ctrl #(.FLEN(FIELD_LEN)) u_ctrl (
    .bclk        (bclk),
    .rst_n       (rst_n),
    .lrclk       (lrclk),
    .wck         (wck),
    .field_start (field_start),
    .frame_start (frame_start),
    .armed_q     (armed_q),
    .emit        (emit),
    .chan        (chan),
    .slot_q      (slot_q)
  );

  // Staging register written by the load strobe.
  always_ff @(negedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q[0] <= '0;
      stage_q[1] <= '0;
    end else if (load) begin
      stage_q[0] <= left_in;
      stage_q[1] <= right_in;
    end
  end

  for (genvar ch = 0; ch < 2; ch++) begin : g_lane
    localparam chan_e MY_CH = (ch == 0) ? CH_LEFT : CH_RIGHT;
    audtx_lane #(.WORD_W(WORD_W)) u_lane (
      .bclk    (bclk),
      .rst_n   (rst_n),
      .capture (frame_start),
      .din     (stage_q[ch]),
      .advance (emit && (chan == MY_CH)),
      .bit_o   (lane_bit[ch]),
      .busy    (lane_busy[ch])
    );
  end

  assign word_active = emit & lane_busy[chan];

  always_comb begin
    sd_d = 1'b0;
    if (!field_start && emit) begin
      sd_d = lane_bit[chan];
    end
  end

  always_ff @(negedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      sd <= 1'b0;
    end else begin
      sd <= sd_d;
    end
  end

endmodule

// File: rtl/audtx_chk.sv
module audtx_chk
  import audtx_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  localparam int unsigned SW    = $clog2(FIELD_LEN + 1),
  localparam int unsigned CW    = $clog2(WORD_W + 1)
) (
  input logic          bclk,
  input logic          rst_n,
  input logic          sd,
  input logic          field_start,
  input logic          armed_q,
  input logic          word_active,
  input logic [SW-1:0] slot_q
);

  // Bits emitted so far in the current field.
  logic [CW-1:0] bits_q;

  always_ff @(negedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
    end else if (field_start) begin
      bits_q <= '0;
    end else if (word_active && bits_q != CW'(WORD_W)) begin
      bits_q <= bits_q + CW'(1);
    end
  end

  a_r1_slot1_zero: assert property (@(negedge bclk) disable iff (!rst_n)
    field_start |=> !sd);

  a_r1_slot_restart: assert property (@(negedge bclk) disable iff (!rst_n)
    field_start |=> (slot_q == SW'(1)));

  a_r3_zero_until_wck: assert property (@(negedge bclk) disable iff (!rst_n)
    (!armed_q && !field_start) |=> !sd);

  a_r6_zero_after_word: assert property (@(negedge bclk) disable iff (!rst_n)
    (armed_q && !field_start && !word_active) |=> !sd);

  a_r8_word_len: assert property (@(negedge bclk) disable iff (!rst_n)
    word_active |-> (bits_q < CW'(WORD_W)));

endmodule

bind audtx_wclk_tx audtx_chk #(.WORD_W(WORD_W)) u_chk (
  .bclk        (bclk),
  .rst_n       (rst_n),
  .sd          (sd),
  .field_start (field_start),
  .armed_q     (armed_q),
  .word_active (word_active),
  .slot_q      (slot_q)
);

// File: tb/sim_audtx_wclk_tx.sv
module sim_audtx_wclk_tx;

  localparam int CLK_PERIOD = 10;

  logic        bclk = 1'b0;
  logic        rst_n;
  logic        lrclk;
  logic        wck;
  logic        load;
  logic [17:0] l18;
  logic [17:0] r18;
  logic        sd16;
  logic        sd18;

  int checks = 0;
  int fails  = 0;

  logic [17:0] stage_l = '0, stage_r = '0;
  logic [17:0] cur_l = '0, cur_r = '0;

  always #(CLK_PERIOD/2) bclk = ~bclk;

  audtx_wclk_tx #(.WORD_W(16)) u0 (
    .bclk(bclk), .rst_n(rst_n), .lrclk(lrclk), .wck(wck), .load(load),
    .left_in(l18[17:2]), .right_in(r18[17:2]), .sd(sd16));

  audtx_wclk_tx #(.WORD_W(18)) u1 (
    .bclk(bclk), .rst_n(rst_n), .lrclk(lrclk), .wck(wck), .load(load),
    .left_in(l18), .right_in(r18), .sd(sd18));

  // Expected bit for slot n, word w bits wide (right-aligned), strobe slot k (0 = none).
  function automatic logic exp_bit(input logic [17:0] word, input int w, input int k, input int n);
    int idx;
    if (k < 1 || n <= k) return 1'b0;
    idx = n - k - 1;
    if (idx >= w) return 1'b0;
    return word[w-1-idx];
  endfunction

  function automatic string tag_for(input int w, input int k, input int n);
    if (n == 1)                      return "R1";
    if (k == 0 || k == 32)           return "R8";
    if (k == 1)                      return "R4";
    if (k == 32 - w)                 return "R5";
    if (k + w > 32)                  return "R8";
    if (n > k + w)                   return "R6";
    return "R3";
  endfunction

  task automatic check(input string tag, input string ctx, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %b expected %b", tag, ctx, got, exp);
    end
  endtask

  // Drives one 32-slot field. k: first word-clock-high slot (0 = never).
  // ld_slot: slot with a load pulse (0 = none).
  task automatic run_field(input logic ch, input int k, input int ld_slot,
                           input logic [17:0] nl, input logic [17:0] nr, input string base);
    logic [17:0] word;
    for (int n = 1; n <= 32; n++) begin
      lrclk = ch;
      if (k >= 1 && n == k)      wck = 1'b1;
      else if (k >= 1 && n > k)  wck = 1'($urandom_range(0, 1));
      else                       wck = 1'b0;
      // R9: the frame takes the staging contents held before its own first edge.
      if (n == 1 && ch == 1'b0) begin
        cur_l = stage_l;
        cur_r = stage_r;
      end
      if (n == ld_slot) begin
        load = 1'b1; l18 = nl; r18 = nr;
        stage_l = nl; stage_r = nr;
      end else begin
        load = 1'b0;
        l18 = 18'($urandom); r18 = 18'($urandom);
      end
      // R2: output set at the falling edge, observed after the next rising edge.
      @(posedge bclk); #1;
      word = ch ? cur_r : cur_l;
      check({base, "/", tag_for(16, k, n)}, $sformatf("w16 ch%0d k%0d slot%0d", ch, k, n),
            sd16, exp_bit(word >> 2, 16, k, n));
      check({base, "/", tag_for(18, k, n)}, $sformatf("w18 ch%0d k%0d slot%0d", ch, k, n),
            sd18, exp_bit(word, 18, k, n));
    end
  endtask

  task automatic run_frame(input int kl, input int kr, input int ld_slot,
                           input logic [17:0] nl, input logic [17:0] nr, input string base);
    // ld_slot 1..32 in left field, 33..64 in right field.
    run_field(1'b0, kl, (ld_slot <= 32) ? ld_slot : 0, nl, nr, base);
    run_field(1'b1, kr, (ld_slot > 32) ? ld_slot - 32 : 0, nl, nr, base);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL R2 watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; lrclk = 1'b0; wck = 1'b1; load = 1'b1;
    l18 = 18'h3FFFF; r18 = 18'h3FFFF;
    repeat (3) @(posedge bclk);
    #1;
    // R10: reset state, load ignored during reset.
    check("R10", "reset w16", sd16, 1'b0);
    check("R10", "reset w18", sd18, 1'b0);
    load = 1'b0; wck = 1'b0;
    rst_n = 1'b1;
    // R10: right field before any frame start is all zero.
    run_field(1'b1, 1, 0, '0, '0, "R10");
    // Load first sample pair in the preceding left field is not possible, so
    // load now in a frame whose own data is still zero.
    run_frame(1, 5, 40, 18'h2A5C3, 18'h15A3C, "R9");
    // R7: left I2S-style, right right-justified for 16-bit.
    run_frame(1, 16, 20, 18'h3C0F1, 18'h0F0F5, "R7");
    // Right-justified 18-bit on left, never-high on right.
    run_frame(14, 0, 1, 18'h12345, 18'h3ABCD, "R7");
    // Frame-start load goes to next frame only; overrun cut-off and slot-32 strobe.
    run_frame(25, 32, 50, 18'h2FFFF, 18'h3FFFE, "R9");
    run_frame(16, 14, 0, '0, '0, "R8");
    for (int f = 0; f < 40; f++) begin
      int kl, kr, ls;
      kl = int'($urandom_range(0, 32));
      kr = int'($urandom_range(0, 32));
      ls = int'($urandom_range(0, 64));
      run_frame(kl, kr, ls, 18'($urandom), 18'($urandom), "R7");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule